// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. A host writes a command byte that picks one of six counting behaviours, then writes the initial count as two bytes, least significant first. The channel then decrements on each count tick (a clock enable qualified on the system clock) and drives a single output whose waveform depends on the selected behaviour: a terminal-count flag, a gate-triggered one-shot, a periodic rate pulse, a square wave, or a one-tick strobe started by software or by the gate.

A gate input either pauses counting, restarts it on a rising edge, or does both, depending on the behaviour. The present count value is always visible on a parallel read port. All inputs are sampled on the rising edge of `clk`. The reset input is asynchronous, and its release is synchronised inside the block over two clock edges.

Top module: `interval_counter_chan`

## Requirements
- R1: A write to address 3 is a command only when data bits 5:4 are 11. Bits 3:1 then select the mode (0 terminal flag, 1 one-shot, 2 rate, 3 square, 4 soft strobe, 5 gated strobe; 6 and 7 act as 2 and 3). Any other access code is ignored. A command stops counting, restarts the two-byte count sequence, and sets the output low for mode 0 and high for every other mode. Writes to addresses 1 and 2 are ignored.
- R2: Count bytes are written to address 0, low byte first. A new count takes effect only after the high byte, and a count of 0 stands for 65536.
- R3: In mode 0 the output goes low on the high-byte write and the count loads on the next tick. The output rises at terminal count, so it is low for N+1 ticks. While the gate is low the count is held.
- R4: In mode 1 a gate rising edge loads the count and drives the output low for N ticks. A rising edge during the pulse reloads the count, which stretches the pulse to N ticks from the new edge.
- R5: In mode 2 the output has a period of N ticks and is low for the last tick of each period. N=10 gives 9 high and 1 low.
- R6: In mode 3 the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating.
- R7: In mode 4 the output stays high for N ticks after the count loads, then goes low for exactly one tick and stays high afterwards. A low gate holds the count.
- R8: Mode 5 behaves like mode 4, except that the count loads on a gate rising edge and not on the write.
- R9: In modes 2 and 3 a low gate forces the output high and holds the count. A gate rising edge reloads the count.
- R10: Without a count tick the count does not change.
- R11: `count_o` shows the live count. After reset the count is 0 and the output is high.
- R12: In mode 2, a count written while the channel is running takes effect at the next reload and not at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count clock enable, one tick per high cycle |
| gate_i | input | 1 | Gate input |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register address |
| wr_data | input | 8 | Host write data |
| out_o | output | 1 | Channel output |
| count_o | output | 16 | Live count value |

## Verification
With a tick on every clock, the mode 0 output changes on the high-byte write edge, a loaded count appears one edge after that write, and every later waveform edge falls a whole number of edges after the load. A gate edge acts on the first clock edge that samples it high. The bench drives inputs on falling edges and checks on falling edges only, counting the exact number of rising edges after each stimulus. Using those counts it compares the output against the high and low lengths worked out from N for each mode: N+1, N, N-1/1, ceil/floor and N/1.

// File: rtl/cntch_pkg.sv
package cntch_pkg;

  typedef enum logic [2:0] {
    MODE_TC      = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_RATE    = 3'd2,
    MODE_SQUARE  = 3'd3,
    MODE_SWSTB   = 3'd4,
    MODE_HWSTB   = 3'd5
  } mode_e;

  localparam logic [1:0] ADDR_CMD  = 2'b11;
  localparam logic [1:0] ADDR_DATA = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;
  localparam int         MODE_LSB  = 1;
  localparam int         ACC_LSB   = 4;

  // field values 6 and 7 fold onto the rate and square modes
  function automatic mode_e fold_mode(input logic [2:0] f);
    return mode_e'({f[2] & ~f[1], f[1], f[0]});
  endfunction

endpackage

// File: rtl/cntch_regif.sv
module cntch_regif
  import cntch_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              cmd_req,
  output mode_e             cmd_mode,
  output mode_e             mode_q,
  output logic              load_req,
  output logic [CNT_W-1:0]  init_q
);

  logic              hi_sel_q, hi_sel_n;
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic [CNT_W-1:0]  init_n;
  mode_e             mode_n;
  logic              data_wr;

  assign cmd_req  = wr_en && (wr_addr == ADDR_CMD) &&
                    (wr_data[ACC_LSB+1:ACC_LSB] == ACC_LOHI);
  assign cmd_mode = fold_mode(wr_data[MODE_LSB+2:MODE_LSB]);
  assign data_wr  = wr_en && (wr_addr == ADDR_DATA);
  assign load_req = data_wr && hi_sel_q;

  always_comb begin
    hi_sel_n = hi_sel_q;
    lo_n     = lo_q;
    init_n   = init_q;
    mode_n   = mode_q;
    if (cmd_req) begin
      mode_n   = cmd_mode;
      hi_sel_n = 1'b0;
    end else if (data_wr) begin
      if (!hi_sel_q) begin
        lo_n     = wr_data;
        hi_sel_n = 1'b1;
      end else begin
        init_n   = {wr_data, lo_q};
        hi_sel_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sel_q <= 1'b0;
      lo_q     <= '0;
      init_q   <= '0;
      mode_q   <= MODE_TC;
    end else begin
      hi_sel_q <= hi_sel_n;
      lo_q     <= lo_n;
      init_q   <= init_n;
      mode_q   <= mode_n;
    end
  end

  // R1: a command always restarts the byte pair at the low byte
  p_cmd_restarts_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !hi_sel_q);

  // R2: a low byte alone never changes the count in effect
  p_low_byte_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !hi_sel_q) |=> $stable(init_q));

endmodule

// File: rtl/cntch_gate_edge.sv
module cntch_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic gate_lvl,
  output logic gate_rise
);

  logic gate_q;

  assign gate_lvl  = gate_i;
  assign gate_rise = gate_i && !gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  // R8: a rising-edge pulse lasts one clock
  p_rise_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);

endmodule

// File: rtl/cntch_core.sv
module cntch_core
  import cntch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             gate_rise,
  input  logic             cmd_req,
  input  mode_e            cmd_mode,
  input  mode_e            mode_q,
  input  logic             load_req,
  input  logic [CNT_W-1:0] init_val,
  output logic             out_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic             out_n, run_q, run_n, have_q, have_n;
  logic             ldp_q, ldp_n, trp_q, trp_n, trig, gated_sq;
  logic [CNT_W-1:0] cnt_n, half_lo, half_hi;
  logic [CNT_W:0]   full_w;

  // a count of zero stands for 2**CNT_W
  assign full_w  = (init_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, init_val};
  assign half_lo = full_w[CNT_W:1];
  assign half_hi = CNT_W'(full_w - {1'b0, half_lo});

  assign trig     = trp_q || gate_rise;
  assign gated_sq = (mode_q == MODE_RATE) || (mode_q == MODE_SQUARE);

  always_comb begin
    cnt_n  = cnt_q;
    out_n  = out_q;
    run_n  = run_q;
    have_n = have_q;
    ldp_n  = ldp_q;
    trp_n  = trp_q || gate_rise;
    if (cmd_req) begin
      out_n  = (cmd_mode == MODE_TC) ? 1'b0 : 1'b1;
      run_n  = 1'b0;
      have_n = 1'b0;
      ldp_n  = 1'b0;
      trp_n  = 1'b0;
    end else begin
      if (tick) begin
        trp_n = 1'b0;
        case (mode_q)
          MODE_TC: begin
            if (ldp_q) begin
              cnt_n = init_val; out_n = 1'b0; run_n = 1'b1; ldp_n = 1'b0;
            end else if (run_q && gate) begin
              cnt_n = cnt_q - ONE;
              if (cnt_q == ONE) out_n = 1'b1;
            end
          end
          MODE_ONESHOT: begin
            ldp_n = 1'b0;
            if (trig && have_q) begin
              cnt_n = init_val; out_n = 1'b0; run_n = 1'b1;
            end else if (run_q) begin
              cnt_n = cnt_q - ONE;
              if (cnt_q == ONE) begin out_n = 1'b1; run_n = 1'b0; end
            end
          end
          MODE_RATE: begin
            ldp_n = 1'b0;
            if ((ldp_q && !run_q) || (trig && have_q)) begin
              cnt_n = init_val; out_n = 1'b1; run_n = 1'b1;
            end else if (run_q && gate) begin
              if (cnt_q == ONE) begin
                cnt_n = init_val; out_n = 1'b1;
              end else begin
                cnt_n = cnt_q - ONE;
                if (cnt_q == TWO) out_n = 1'b0;
              end
            end
          end
          MODE_SQUARE: begin
            ldp_n = 1'b0;
            if ((ldp_q && !run_q) || (trig && have_q)) begin
              cnt_n = half_hi; out_n = 1'b1; run_n = 1'b1;
            end else if (run_q && gate) begin
              if (cnt_q == ONE) begin
                out_n = !out_q;
                cnt_n = out_q ? half_lo : half_hi;
              end else begin
                cnt_n = cnt_q - ONE;
              end
            end
          end
          MODE_SWSTB: begin
            if (ldp_q) begin
              cnt_n = init_val; out_n = 1'b1; run_n = 1'b1; ldp_n = 1'b0;
            end else if (run_q) begin
              if (!out_q) begin
                out_n = 1'b1; run_n = 1'b0;
              end else if (gate) begin
                cnt_n = cnt_q - ONE;
                if (cnt_q == ONE) out_n = 1'b0;
              end
            end
          end
          MODE_HWSTB: begin
            ldp_n = 1'b0;
            if (trig && have_q) begin
              cnt_n = init_val; out_n = 1'b1; run_n = 1'b1;
            end else if (run_q) begin
              if (!out_q) begin
                out_n = 1'b1; run_n = 1'b0;
              end else begin
                cnt_n = cnt_q - ONE;
                if (cnt_q == ONE) out_n = 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
      if (gated_sq && !gate) out_n = 1'b1;
      if (load_req) begin
        ldp_n  = 1'b1;
        have_n = 1'b1;
        if (mode_q == MODE_TC) begin
          out_n = 1'b0;
          run_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b1;
      run_q  <= 1'b0;
      have_q <= 1'b0;
      ldp_q  <= 1'b0;
      trp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      out_q  <= out_n;
      run_q  <= run_n;
      have_q <= have_n;
      ldp_q  <= ldp_n;
      trp_q  <= trp_n;
    end
  end

  // R10: without a tick the count is frozen
  p_idle_count_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R9: low gate in rate or square mode holds the output high
  p_gate_low_out_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_req && gated_sq && !gate) |=> out_q);

  // R7: a strobe lasts a single tick
  p_strobe_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_req && tick && run_q && !out_q &&
     ((mode_q == MODE_SWSTB) || (mode_q == MODE_HWSTB))) |=> out_q);

  // R3: the high-byte write in mode 0 pulls the output low
  p_tc_low_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_req && load_req && (mode_q == MODE_TC)) |=> !out_q);

  // R4: the one-shot pulse stays low until the count runs out
  p_oneshot_low_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_req && tick && (mode_q == MODE_ONESHOT) && run_q && !out_q &&
     (cnt_q != ONE)) |=> !out_q);

endmodule

// File: rtl/interval_counter_chan.sv
module interval_counter_chan
  import cntch_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              gate_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              out_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [1:0]       rst_pipe;
  logic             rst_int;
  logic             cmd_req, load_req, gate_lvl, gate_rise;
  mode_e            cmd_mode, mode_q;
  logic [CNT_W-1:0] init_q;

  // asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  cntch_regif #(.BYTE_W(BYTE_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_int),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmd_req  (cmd_req),
    .cmd_mode (cmd_mode),
    .mode_q   (mode_q),
    .load_req (load_req),
    .init_q   (init_q)
  );

  cntch_gate_edge u_gate (
    .clk       (clk),
    .rst_n     (rst_int),
    .gate_i    (gate_i),
    .gate_lvl  (gate_lvl),
    .gate_rise (gate_rise)
  );

  cntch_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int),
    .tick      (cnt_tick),
    .gate      (gate_lvl),
    .gate_rise (gate_rise),
    .cmd_req   (cmd_req),
    .cmd_mode  (cmd_mode),
    .mode_q    (mode_q),
    .load_req  (load_req),
    .init_val  (init_q),
    .out_q     (out_o),
    .cnt_q     (count_o)
  );

endmodule

// File: tb/interval_counter_chan_test.sv
module interval_counter_chan_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, cnt_tick, gate_i, wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        out_o;
  logic [15:0] count_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  interval_counter_chan uut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate_i(gate_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_o(out_o), .count_o(count_o)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_count(input logic [15:0] n);
    wr(2'd0, n[7:0]);
    wr(2'd0, n[15:8]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cnt_tick = 1'b1; gate_i = 1'b1; wr_en = 1'b0;
    wr_addr = 2'd0; wr_data = 8'd0;
    step(3);
    rst_n = 1'b1;
    step(4);
    check("R11 reset out", 32'(out_o), 32'd1);
    check("R11 reset count", 32'(count_o), 32'd0);
  endtask

  task automatic t_mode0;
    logic [15:0] c0;
    gate_i = 1'b1;
    wr(2'd3, 8'h30);
    check("R1 mode0 command drives low", 32'(out_o), 32'd0);
    c0 = count_o;
    wr(2'd0, 8'd5);
    step(2);
    check("R2 low byte alone has no effect", 32'(count_o), 32'(c0));
    wr(2'd0, 8'd0);
    check("R3 low after write", 32'(out_o), 32'd0);
    for (int k = 1; k <= 6; k++) begin
      step(1);
      if (k == 1) check("R11 live count after load", 32'(count_o), 32'd5);
      check("R3 terminal flag timing", 32'(out_o), (k >= 6) ? 32'd1 : 32'd0);
    end
    wr(2'd3, 8'h10);
    wr(2'd2, 8'h30);
    step(2);
    check("R1 bad access code and address ignored", 32'(out_o), 32'd1);
  endtask

  task automatic t_mode0_gate;
    gate_i = 1'b0;
    wr(2'd3, 8'h30);
    wr_count(16'd3);
    step(1);
    check("R3 loaded with gate low", 32'(count_o), 32'd3);
    step(4);
    check("R3 gate low holds count", 32'(count_o), 32'd3);
    check("R3 gate low keeps out low", 32'(out_o), 32'd0);
    gate_i = 1'b1;
    step(2);
    check("R3 still low before terminal", 32'(out_o), 32'd0);
    step(1);
    check("R3 high at terminal", 32'(out_o), 32'd1);
    check("R3 count reached zero", 32'(count_o), 32'd0);
  endtask

  task automatic t_zero_count;
    gate_i = 1'b1;
    wr(2'd3, 8'h30);
    wr_count(16'd0);
    step(1);
    check("R2 zero loaded", 32'(count_o), 32'd0);
    step(1);
    check("R2 zero wraps", 32'(count_o), 32'hFFFF);
    step(65534);
    check("R2 zero is 65536 still low", 32'(out_o), 32'd0);
    step(1);
    check("R2 zero is 65536 rises", 32'(out_o), 32'd1);
  endtask

  task automatic t_mode1;
    gate_i = 1'b0;
    wr(2'd3, 8'h32);
    wr_count(16'd4);
    step(3);
    check("R4 idle until trigger", 32'(out_o), 32'd1);
    gate_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step(1);
      if (k == 1) check("R4 trigger loads count", 32'(count_o), 32'd4);
      check("R4 pulse width", 32'(out_o), (k <= 4) ? 32'd0 : 32'd1);
    end
    gate_i = 1'b0;
    step(2);
    gate_i = 1'b1;
    step(2);
    check("R4 second pulse low", 32'(out_o), 32'd0);
    gate_i = 1'b0;
    step(1);
    gate_i = 1'b1;
    step(1);
    check("R4 retrigger reloads", 32'(count_o), 32'd4);
    step(3);
    check("R4 retrigger stretches pulse", 32'(out_o), 32'd0);
    step(1);
    check("R4 stretched pulse ends", 32'(out_o), 32'd1);
  endtask

  task automatic t_mode2;
    logic [15:0] c;
    logic        o;
    gate_i = 1'b1;
    wr(2'd3, 8'h34);
    wr_count(16'd10);
    for (int k = 1; k <= 30; k++) begin
      step(1);
      check("R5 rate period 10", 32'(out_o), (k % 10 == 0) ? 32'd0 : 32'd1);
    end
    wr(2'd3, 8'h34);
    wr_count(16'd4);
    step(4);
    check("R5 rate low at N", 32'(out_o), 32'd0);
    wr_count(16'd6);
    step(2);
    check("R12 old period finishes", 32'(out_o), 32'd0);
    step(4);
    check("R12 not low at old period", 32'(out_o), 32'd1);
    step(2);
    check("R12 new period used after reload", 32'(out_o), 32'd0);
    step(2);
    gate_i = 1'b0;
    c = count_o;
    step(1);
    check("R9 gate low forces high", 32'(out_o), 32'd1);
    check("R9 gate low holds count", 32'(count_o), 32'(c));
    step(2);
    check("R9 count still held", 32'(count_o), 32'(c));
    gate_i = 1'b1;
    step(1);
    check("R9 gate rise reloads", 32'(count_o), 32'd6);
    step(4);
    check("R9 high before new low", 32'(out_o), 32'd1);
    step(1);
    check("R9 low one period after rise", 32'(out_o), 32'd0);
    step(3);
    cnt_tick = 1'b0;
    c = count_o;
    o = out_o;
    step(3);
    check("R10 no tick count frozen", 32'(count_o), 32'(c));
    check("R10 no tick out frozen", 32'(out_o), 32'(o));
    cnt_tick = 1'b1;
  endtask

  task automatic t_mode3(input logic [7:0] cmd, input int n);
    int hi;
    hi = n - n / 2;
    gate_i = 1'b1;
    wr(2'd3, cmd);
    wr_count(16'(n));
    for (int k = 1; k <= 2 * n; k++) begin
      step(1);
      check("R6 square halves", 32'(out_o), (((k - 1) % n) < hi) ? 32'd1 : 32'd0);
    end
  endtask

  task automatic t_mode4;
    gate_i = 1'b1;
    wr(2'd3, 8'h38);
    wr(2'd0, 8'd9);
    wr(2'd3, 8'h38);
    wr_count(16'd3);
    for (int k = 1; k <= 8; k++) begin
      step(1);
      if (k == 1) check("R1 command restarts byte pair", 32'(count_o), 32'd3);
      check("R7 soft strobe", 32'(out_o), (k == 4) ? 32'd0 : 32'd1);
    end
  endtask

  task automatic t_mode5;
    gate_i = 1'b0;
    wr(2'd3, 8'h3A);
    wr_count(16'd3);
    step(3);
    check("R8 no strobe before gate", 32'(out_o), 32'd1);
    gate_i = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      step(1);
      if (k == 1) check("R8 gate edge loads", 32'(count_o), 32'd3);
      check("R8 gated strobe", 32'(out_o), (k == 4) ? 32'd0 : 32'd1);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mode0();
    t_mode0_gate();
    t_zero_count();
    t_mode1();
    t_mode2();
    t_mode3(8'h36, 5);
    t_mode3(8'h3E, 6);
    t_mode4();
    t_mode5();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule